// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a signed-agnostic 32-bit position count from two phase inputs and an index input. The inputs must already be clean and synchronous to the block clock. A 3-bit mode selects how the phases are decoded. Two quadrature modes count every transition (x4), and two count only A transitions (x2). In each pair, one variant wraps at the full count range and the other wraps at a programmable maximum. The remaining modes are two pulse-counting modes, a directional mode where the direction comes only from a control field, and a reserved code that never counts.

An index rising edge can reload the count. The reload goes to zero when the block is counting up and to the programmed maximum when it is counting down. The reload can happen on every index edge, or only on the first one until software re-arms it. Five sticky flags record index, compare match, wrap, direction change and phase error. Each flag is cleared by a write-one strobe. The flags are combined with per-flag enables into a single interrupt. Software writes the count through a plain strobe, and only while the block is disabled.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 1 (up), all flags are 0, the first-index-done output is 0 and the interrupt is 0.
- R2: In modes 000 and 010, every single-phase transition is one count event. The phase sequence AB = 00,10,11,01 counts up, the reverse sequence counts down, and the direction output follows the last event.
- R3: In modes 001 and 011, only A transitions count. B transitions change neither the count nor the direction.
- R4: In modes 000 to 011, a sample in which A and B both change does not count. It sets the phase-error flag, bit 4.
- R5: In mode 100, the selected A edges count, up while B is high and down while B is low. The edge field selects the edges: 00 falling, 01 rising, 10 both, 11 none.
- R6: In mode 101, the selected A edges count up and the selected B edges count down. A sample in which both are selected does not count.
- R7: Direction source 10 forces up and 11 forces down, in every mode. In mode 110 with source 00, the selected A edges count in the current direction. Mode 111 never counts.
- R8: Modes 000, 001, 100, 101 and 110 wrap between 0xFFFFFFFF and 0. Modes 010 and 011 wrap between the maximum input and 0. Every wrap sets flag bit 2.
- R9: With compare enabled, flag bit 1 sets on the cycle after the count equals the compare input. With compare disabled, it never sets.
- R10: Every rising index edge sets flag bit 0. With reload enabled, the edge loads 0 if the direction output is 1 and loads the maximum otherwise, and a reload overrides a count event in the same cycle.
- R11: With first-only set, only the first enabled reload takes effect and raises the first-index-done output. A re-arm pulse clears that output and allows one more reload.
- R12: Any change of the direction output sets flag bit 3.
- R13: Flags are sticky until written with a 1 on the clear vector, and a set in the same cycle wins over the clear. The interrupt is the OR of the flags masked by the enable vector.
- R14: A count write takes effect only while the block is disabled. While disabled, the block neither counts nor reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable |
| mode_i | input | 3 | Counting mode |
| edge_sel_i | input | 2 | Edge selection for non-quadrature modes |
| dir_src_i | input | 2 | Direction source: 00 decoded, 10 forced up, 11 forced down |
| cmp_en_i | input | 1 | Compare enable |
| idx_rld_en_i | input | 1 | Index reload enable |
| idx_first_only_i | input | 1 | Reload only on the first index |
| rearm_i | input | 1 | Re-arm pulse for first-only reload |
| cnt_max_i | input | 32 | Preset maximum |
| cnt_cmp_i | input | 32 | Compare value |
| cnt_wr_i | input | 1 | Count write strobe |
| cnt_wdata_i | input | 32 | Count write data |
| phase_a_i | input | 1 | Phase A |
| phase_b_i | input | 1 | Phase B |
| index_i | input | 1 | Index |
| flag_clr_i | input | 5 | Write-one clear per flag |
| irq_en_i | input | 5 | Interrupt enable per flag |
| cnt_o | output | 32 | Position count |
| dir_o | output | 1 | Direction, 1 = up |
| flags_o | output | 5 | Sticky flags: 0 index, 1 compare, 2 wrap, 3 direction change, 4 phase error |
| first_idx_done_o | output | 1 | First-only reload has happened |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions assume that every input is synchronous to the clock and changes at most once per cycle. They also assume that the index input before reset release is not taken as an edge. The random part of the stimulus walks the quadrature phases only through legal single-step moves, so each count change can be predicted one for one. Both-phase flips, same-cycle index and phase edges, and set-versus-clear collisions are driven only in directed steps whose outcome the requirements fix. All inputs change on the falling clock edge.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [2:0] {
    MODE_X4_FREE = 3'b000,
    MODE_X2_FREE = 3'b001,
    MODE_X4_CMP  = 3'b010,
    MODE_X2_CMP  = 3'b011,
    MODE_PC_STEP = 3'b100,
    MODE_PC_UPDN = 3'b101,
    MODE_DIRECT  = 3'b110,
    MODE_RSVD    = 3'b111
  } qpc_mode_e;

  typedef enum logic [1:0] {
    EDGE_FALL = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_NONE = 2'b11
  } qpc_edge_e;

  localparam int unsigned FLAG_N   = 5;
  localparam int unsigned FLG_IDX  = 0;
  localparam int unsigned FLG_CMP  = 1;
  localparam int unsigned FLG_WRAP = 2;
  localparam int unsigned FLG_DCHG = 3;
  localparam int unsigned FLG_PERR = 4;

  typedef struct packed {
    logic evt;
    logic dir_vld;
    logic up;
    logic perr;
    logic idx_rise;
  } qpc_dec_s;
endpackage

// File: rtl/qpc_phase_decode.sv
module qpc_phase_decode
  import qpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a_i,
  input  logic      b_i,
  input  logic      idx_i,
  input  qpc_mode_e mode_i,
  input  qpc_edge_e edge_sel_i,
  output qpc_dec_s  dec_o
);
  localparam int unsigned CH_N = 3;
  localparam int unsigned PH_N = 2;

  logic [CH_N-1:0] raw, smp_q, chg, rise;
  logic [PH_N-1:0] fall, hit;
  logic            quad_up;

  assign raw = {idx_i, b_i, a_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smp_q <= '0;
    else         smp_q <= raw;
  end

  assign chg  = raw ^ smp_q;
  assign rise = chg & raw;
  assign fall = chg[PH_N-1:0] & ~raw[PH_N-1:0];

  for (genvar g = 0; g < PH_N; g++) begin : g_hit
    assign hit[g] = (edge_sel_i == EDGE_FALL) ? fall[g] :
                    (edge_sel_i == EDGE_RISE) ? rise[g] :
                    (edge_sel_i == EDGE_BOTH) ? chg[g]  : 1'b0;
  end

  // A leading B: new A differs from previous B
  assign quad_up = raw[0] ^ smp_q[1];

  always_comb begin
    dec_o          = '0;
    dec_o.idx_rise = rise[2];
    unique case (mode_i)
      MODE_X4_FREE, MODE_X4_CMP: begin
        dec_o.evt     = chg[0] ^ chg[1];
        dec_o.dir_vld = 1'b1;
        dec_o.up      = quad_up;
        dec_o.perr    = chg[0] & chg[1];
      end
      MODE_X2_FREE, MODE_X2_CMP: begin
        dec_o.evt     = chg[0] & ~chg[1];
        dec_o.dir_vld = 1'b1;
        dec_o.up      = quad_up;
        dec_o.perr    = chg[0] & chg[1];
      end
      MODE_PC_STEP: begin
        dec_o.evt     = hit[0];
        dec_o.dir_vld = 1'b1;
        dec_o.up      = raw[1];
      end
      MODE_PC_UPDN: begin
        dec_o.evt     = hit[0] ^ hit[1];
        dec_o.dir_vld = 1'b1;
        dec_o.up      = hit[0];
      end
      MODE_DIRECT: begin
        dec_o.evt     = hit[0];
        dec_o.dir_vld = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qpc_pos_counter.sv
module qpc_pos_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cmp_mode_i,
  input  logic             evt_i,
  input  logic             dir_vld_i,
  input  logic             evt_up_i,
  input  logic             force_i,
  input  logic             force_up_i,
  input  logic             idx_rise_i,
  input  logic             rld_en_i,
  input  logic             first_only_i,
  input  logic             rearm_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             wrap_o,
  output logic             dchg_o,
  output logic             first_done_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt, limit;
  logic             dir_q, dir_nxt, armed_q, rld_fire, step_up;

  assign limit    = cmp_mode_i ? max_i : ALL_ONES;
  assign rld_fire = en_i & rld_en_i & idx_rise_i & (~first_only_i | armed_q);
  assign step_up  = force_i ? force_up_i : (dir_vld_i ? evt_up_i : dir_q);

  always_comb begin
    dir_nxt = dir_q;
    if (en_i) begin
      if (force_i)                dir_nxt = force_up_i;
      else if (evt_i && dir_vld_i) dir_nxt = evt_up_i;
    end
  end

  always_comb begin
    cnt_nxt = cnt_q;
    wrap_o  = 1'b0;
    if (!en_i) begin
      if (wr_i) cnt_nxt = wdata_i;
    end else if (rld_fire) begin
      cnt_nxt = dir_q ? '0 : max_i;
    end else if (evt_i) begin
      if (step_up) begin
        if (cnt_q == limit) begin
          cnt_nxt = '0;
          wrap_o  = 1'b1;
        end else begin
          cnt_nxt = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_nxt = limit;
          wrap_o  = 1'b1;
        end else begin
          cnt_nxt = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dir_q   <= 1'b1;
      armed_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
      if (rearm_i)                        armed_q <= 1'b1;
      else if (rld_fire && first_only_i)  armed_q <= 1'b0;
    end
  end

  assign dchg_o       = dir_nxt ^ dir_q;
  assign cnt_o        = cnt_q;
  assign dir_o        = dir_q;
  assign first_done_o = ~armed_q;
endmodule

// File: rtl/qpc_status_flags.sv
module qpc_status_flags #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] irq_en_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  logic [N-1:0] flg_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flg_q[g] <= 1'b0;
      else if (set_i[g]) flg_q[g] <= 1'b1;
      else if (clr_i[g]) flg_q[g] <= 1'b0;
    end
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & irq_en_i);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [2:0]        mode_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [1:0]        dir_src_i,
  input  logic              cmp_en_i,
  input  logic              idx_rld_en_i,
  input  logic              idx_first_only_i,
  input  logic              rearm_i,
  input  logic [CNT_W-1:0]  cnt_max_i,
  input  logic [CNT_W-1:0]  cnt_cmp_i,
  input  logic              cnt_wr_i,
  input  logic [CNT_W-1:0]  cnt_wdata_i,
  input  logic              phase_a_i,
  input  logic              phase_b_i,
  input  logic              index_i,
  input  logic [FLAG_N-1:0] flag_clr_i,
  input  logic [FLAG_N-1:0] irq_en_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic [FLAG_N-1:0] flags_o,
  output logic              first_idx_done_o,
  output logic              irq_o
);
  qpc_mode_e        mode;
  qpc_dec_s         dec;
  logic             cmp_mode, wrap, dchg;
  logic [FLAG_N-1:0] flag_set;

  assign mode     = qpc_mode_e'(mode_i);
  assign cmp_mode = (mode == MODE_X4_CMP) || (mode == MODE_X2_CMP);

  qpc_phase_decode i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (phase_a_i),
    .b_i        (phase_b_i),
    .idx_i      (index_i),
    .mode_i     (mode),
    .edge_sel_i (qpc_edge_e'(edge_sel_i)),
    .dec_o      (dec)
  );

  qpc_pos_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .cmp_mode_i   (cmp_mode),
    .evt_i        (dec.evt),
    .dir_vld_i    (dec.dir_vld),
    .evt_up_i     (dec.up),
    .force_i      (dir_src_i[1]),
    .force_up_i   (~dir_src_i[0]),
    .idx_rise_i   (dec.idx_rise),
    .rld_en_i     (idx_rld_en_i),
    .first_only_i (idx_first_only_i),
    .rearm_i      (rearm_i),
    .max_i        (cnt_max_i),
    .wr_i         (cnt_wr_i),
    .wdata_i      (cnt_wdata_i),
    .cnt_o        (cnt_o),
    .dir_o        (dir_o),
    .wrap_o       (wrap),
    .dchg_o       (dchg),
    .first_done_o (first_idx_done_o)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_IDX]  = en_i & dec.idx_rise;
    flag_set[FLG_CMP]  = en_i & cmp_en_i & (cnt_o == cnt_cmp_i);
    flag_set[FLG_WRAP] = wrap;
    flag_set[FLG_DCHG] = dchg;
    flag_set[FLG_PERR] = en_i & dec.perr;
  end

  qpc_status_flags #(.N(FLAG_N)) i_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (flag_set),
    .clr_i    (flag_clr_i),
    .irq_en_i (irq_en_i),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/qpc_checker.sv
module qpc_checker
  import qpc_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [2:0]        mode_i,
  input logic [1:0]        dir_src_i,
  input logic              cmp_en_i,
  input logic              idx_rld_en_i,
  input logic              idx_first_only_i,
  input logic              rearm_i,
  input logic [CNT_W-1:0]  cnt_max_i,
  input logic [CNT_W-1:0]  cnt_cmp_i,
  input logic              cnt_wr_i,
  input logic [CNT_W-1:0]  cnt_wdata_i,
  input logic              index_i,
  input logic [FLAG_N-1:0] flag_clr_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              dir_o,
  input logic [FLAG_N-1:0] flags_o,
  input logic              first_idx_done_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && cnt_wr_i |=> cnt_o == $past(cnt_wdata_i)); // R14

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !cnt_wr_i |=> $stable(cnt_o)); // R14

  AST_RSVD_NO_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && mode_i == 3'b111 && !idx_rld_en_i |=> $stable(cnt_o)); // R7

  AST_FORCE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && dir_src_i == 2'b10 |=> dir_o); // R7

  AST_WRAP_POINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_o[FLG_WRAP]) |-> ($past(cnt_o) == '0) ||
      ($past(cnt_o) == (($past(mode_i) == 3'b010 || $past(mode_i) == 3'b011) ?
                        $past(cnt_max_i) : ALL_ONES))); // R8

  AST_CMP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cmp_en_i && cnt_o == cnt_cmp_i |=> flags_o[FLG_CMP]); // R9

  AST_IDX_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && idx_rld_en_i && !idx_first_only_i && index_i && !$past(index_i)
      |=> cnt_o == ($past(dir_o) ? '0 : $past(cnt_max_i))); // R10

  AST_FIRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_idx_done_o && !rearm_i |=> first_idx_done_o); // R11

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |flags_o |=> (($past(flags_o) & ~$past(flag_clr_i) & ~flags_o) == '0)); // R13
endmodule

bind quad_pos_counter qpc_checker #(.CNT_W(CNT_W)) i_qpc_checker (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .en_i             (en_i),
  .mode_i           (mode_i),
  .dir_src_i        (dir_src_i),
  .cmp_en_i         (cmp_en_i),
  .idx_rld_en_i     (idx_rld_en_i),
  .idx_first_only_i (idx_first_only_i),
  .rearm_i          (rearm_i),
  .cnt_max_i        (cnt_max_i),
  .cnt_cmp_i        (cnt_cmp_i),
  .cnt_wr_i         (cnt_wr_i),
  .cnt_wdata_i      (cnt_wdata_i),
  .index_i          (index_i),
  .flag_clr_i       (flag_clr_i),
  .cnt_o            (cnt_o),
  .dir_o            (dir_o),
  .flags_o          (flags_o),
  .first_idx_done_o (first_idx_done_o)
);

// File: tb/test_quad_pos_counter.sv
`timescale 1ns/1ps
module test_quad_pos_counter;
  localparam int unsigned CNT_W = 32;
  localparam int unsigned FN    = 5;
  localparam int unsigned WD_CYCLES = 100000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic [2:0]       mode_i = 3'b000;
  logic [1:0]       edge_sel_i = 2'b10;
  logic [1:0]       dir_src_i = 2'b00;
  logic             cmp_en_i = 1'b0;
  logic             idx_rld_en_i = 1'b0;
  logic             idx_first_only_i = 1'b0;
  logic             rearm_i = 1'b0;
  logic [CNT_W-1:0] cnt_max_i = '0;
  logic [CNT_W-1:0] cnt_cmp_i = '0;
  logic             cnt_wr_i = 1'b0;
  logic [CNT_W-1:0] cnt_wdata_i = '0;
  logic             phase_a_i = 1'b0;
  logic             phase_b_i = 1'b0;
  logic             index_i = 1'b0;
  logic [FN-1:0]    flag_clr_i = '0;
  logic [FN-1:0]    irq_en_i = '0;
  logic [CNT_W-1:0] cnt_o;
  logic             dir_o;
  logic [FN-1:0]    flags_o;
  logic             first_idx_done_o;
  logic             irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int pos = 0;
  logic [CNT_W-1:0] exp_cnt;
  logic exp_dir;

  always #2 clk_i = ~clk_i;

  quad_pos_counter #(.CNT_W(CNT_W)) i_quad_pos_counter (.*);

  function automatic logic [1:0] gray_ab(input int p);
    case (p & 3)
      0:       return 2'b00;
      1:       return 2'b10;
      2:       return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] step_val(input logic [CNT_W-1:0] v, input logic up);
    return up ? v + 1 : v - 1;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic move(input int d);
    pos = (pos + d + 4) % 4;
    {phase_a_i, phase_b_i} = gray_ab(pos);
    tick();
  endtask

  task automatic clear_all();
    flag_clr_i = '1;
    tick();
    flag_clr_i = '0;
  endtask

  task automatic load(input logic [CNT_W-1:0] v);
    en_i = 1'b0;
    cnt_wr_i = 1'b1;
    cnt_wdata_i = v;
    tick();
    cnt_wr_i = 1'b0;
  endtask

  initial begin
    #(4 * WD_CYCLES);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 cnt", cnt_o, 0);
    chk("R1 dir", dir_o, 1);
    chk("R1 flags", flags_o, 0);
    chk("R1 first", first_idx_done_o, 0);
    chk("R1 irq", irq_o, 0);

    // R14 load while disabled, no counting while disabled
    load(100);
    chk("R14 load", cnt_o, 100);
    phase_a_i = 1'b1; tick();
    phase_b_i = 1'b1; tick();
    phase_a_i = 1'b0; tick();
    phase_b_i = 1'b0; tick();
    chk("R14 idle", cnt_o, 100);
    en_i = 1'b1;
    cnt_wr_i = 1'b1; cnt_wdata_i = 5; tick(); cnt_wr_i = 1'b0;
    chk("R14 write ignored", cnt_o, 100);

    // R2 directed quadrature
    pos = 0;
    for (int i = 0; i < 4; i++) move(1);
    chk("R2 fwd", cnt_o, 104);
    chk("R2 dir up", dir_o, 1);
    move(-1);
    chk("R2 back", cnt_o, 103);
    chk("R2 dir down", dir_o, 0);
    chk("R12 dirchg", flags_o[3], 1);
    clear_all();
    chk("R13 cleared", flags_o, 0);

    // R2 random legal walk
    exp_cnt = 103;
    exp_dir = 1'b0;
    for (int i = 0; i < 300; i++) begin
      int r;
      r = int'($urandom % 3);
      if (r == 0) begin move(1); exp_cnt = step_val(exp_cnt, 1'b1); exp_dir = 1'b1; end
      else if (r == 1) begin move(-1); exp_cnt = step_val(exp_cnt, 1'b0); exp_dir = 1'b0; end
      else tick();
    end
    chk("R2 walk cnt", cnt_o, exp_cnt);
    chk("R2 walk dir", dir_o, exp_dir);

    // R4 phase error
    clear_all();
    move(2);
    chk("R4 no count", cnt_o, exp_cnt);
    chk("R4 perr", flags_o[4], 1);
    clear_all();

    // R3 x2 mode
    mode_i = 3'b001;
    tick();
    for (int i = 0; i < 4; i++) move(1);
    chk("R3 x2 cycle", cnt_o, exp_cnt + 2);

    // R8 free wrap
    load(32'hFFFF_FFFE);
    en_i = 1'b1; mode_i = 3'b000;
    clear_all();
    move(1);
    chk("R8 pre wrap", flags_o[2], 0);
    move(1);
    chk("R8 free over", cnt_o, 0);
    chk("R8 wrap flag", flags_o[2], 1);
    move(-1);
    chk("R8 free under", cnt_o, 32'hFFFF_FFFF);

    // R8 compare-mode wrap
    cnt_max_i = 9;
    load(9);
    mode_i = 3'b010; en_i = 1'b1;
    clear_all();
    move(1);
    chk("R8 cmp over", cnt_o, 0);
    chk("R8 cmp flag", flags_o[2], 1);
    clear_all();
    move(-1);
    chk("R8 cmp under", cnt_o, 9);
    chk("R8 cmp flag2", flags_o[2], 1);

    // R9 compare flag
    clear_all();
    cnt_cmp_i = 1; cmp_en_i = 1'b1;
    tick();
    chk("R9 no match", flags_o[1], 0);
    move(1); tick();
    chk("R9 at 0", flags_o[1], 0);
    move(1); tick();
    chk("R9 cnt", cnt_o, 1);
    chk("R9 match", flags_o[1], 1);
    cmp_en_i = 1'b0;
    clear_all();
    tick(); tick();
    chk("R9 disabled", flags_o[1], 0);

    // R10 index reload
    mode_i = 3'b000; idx_rld_en_i = 1'b1;
    clear_all();
    index_i = 1'b1; tick();
    chk("R10 up reload", cnt_o, 0);
    chk("R10 idx flag", flags_o[0], 1);
    index_i = 1'b0; tick();
    move(-1);
    index_i = 1'b1; tick();
    chk("R10 down reload", cnt_o, 9);
    index_i = 1'b0; tick();
    move(-1);
    chk("R10 pre", cnt_o, 8);
    pos = (pos + 3) % 4;
    {phase_a_i, phase_b_i} = gray_ab(pos);
    index_i = 1'b1; tick();
    chk("R10 reload wins", cnt_o, 9);
    index_i = 1'b0; tick();

    // R11 first-only
    idx_first_only_i = 1'b1;
    move(1);
    chk("R11 pre", cnt_o, 10);
    index_i = 1'b1; tick();
    chk("R11 first reload", cnt_o, 0);
    chk("R11 done", first_idx_done_o, 1);
    index_i = 1'b0; tick();
    move(1);
    index_i = 1'b1; tick();
    chk("R11 second ignored", cnt_o, 1);
    index_i = 1'b0; tick();
    rearm_i = 1'b1; tick(); rearm_i = 1'b0;
    chk("R11 rearm", first_idx_done_o, 0);
    index_i = 1'b1; tick();
    chk("R11 rearmed reload", cnt_o, 0);
    chk("R11 done again", first_idx_done_o, 1);
    index_i = 1'b0; tick();
    idx_first_only_i = 1'b0; idx_rld_en_i = 1'b0;

    // R5 step mode
    load(50);
    mode_i = 3'b100; edge_sel_i = 2'b11;
    phase_a_i = 1'b0; phase_b_i = 1'b0; tick();
    en_i = 1'b1;
    phase_b_i = 1'b1; tick();
    phase_a_i = 1'b1; tick();
    phase_a_i = 1'b0; tick();
    chk("R5 none", cnt_o, 50);
    edge_sel_i = 2'b01;
    for (int i = 0; i < 4; i++) begin phase_a_i = ~phase_a_i; tick(); end
    chk("R5 rising up", cnt_o, 52);
    edge_sel_i = 2'b10;
    phase_b_i = 1'b0; tick();
    for (int i = 0; i < 2; i++) begin phase_a_i = ~phase_a_i; tick(); end
    chk("R5 both down", cnt_o, 50);
    edge_sel_i = 2'b00;
    phase_b_i = 1'b1; tick();
    phase_a_i = 1'b1; tick();
    phase_a_i = 1'b0; tick();
    chk("R5 falling", cnt_o, 51);

    // R6 up/down channels
    mode_i = 3'b101; edge_sel_i = 2'b10;
    phase_a_i = 1'b1; tick();
    phase_a_i = 1'b0; tick();
    chk("R6 a up", cnt_o, 53);
    phase_b_i = 1'b0; tick();
    chk("R6 b down", cnt_o, 52);
    phase_a_i = 1'b1; phase_b_i = 1'b1; tick();
    chk("R6 both", cnt_o, 52);

    // R7 directional and forced direction
    mode_i = 3'b110;
    phase_a_i = 1'b0; tick();
    chk("R7 keep dir", cnt_o, 51);
    dir_src_i = 2'b10; tick();
    chk("R7 force up", dir_o, 1);
    phase_a_i = 1'b1; tick();
    chk("R7 dir cnt", cnt_o, 52);
    phase_b_i = 1'b1; tick();
    mode_i = 3'b000; dir_src_i = 2'b11;
    pos = 2;
    move(1);
    chk("R7 force down", cnt_o, 51);
    chk("R7 dir down", dir_o, 0);
    mode_i = 3'b111; dir_src_i = 2'b00;
    phase_a_i = 1'b1; tick();
    phase_b_i = 1'b0; tick();
    chk("R7 reserved", cnt_o, 51);

    // R13 flags and interrupt
    mode_i = 3'b000;
    clear_all();
    index_i = 1'b1; tick();
    chk("R13 set", flags_o[0], 1);
    chk("R13 masked", irq_o, 0);
    irq_en_i = 5'b00001; tick();
    chk("R13 irq", irq_o, 1);
    index_i = 1'b0; tick();
    index_i = 1'b1; flag_clr_i = 5'b00001; tick(); flag_clr_i = '0;
    chk("R13 set wins", flags_o[0], 1);
    clear_all();
    chk("R13 clr", flags_o, 0);
    chk("R13 irq low", irq_o, 0);
    phase_a_i = ~phase_a_i; phase_b_i = ~phase_b_i; tick();
    chk("R13 perr only", flags_o, 5'b10000);
    chk("R13 irq mask", irq_o, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule